// File: doc/BRIEF.md
# Programmable Burst Read Sequencer

This block turns a single address-latch request into a timed series of read beats toward a memory array. A 16-bit configuration word, written through a simple write port, selects how long the first access takes, how many burst clocks separate later beats, whether the addresses within a burst run linearly or in interleaved (XOR) order, whether a fixed-length burst wraps inside its aligned block, which edge of the burst clock counts, and whether the ready output leads each beat by one burst clock. After reset the sequencer is in asynchronous mode and ignores all requests.

The burst clock is modelled as the system clock divided by two. A phase bit toggles on every system clock edge once reset is released. Beats are counted only on the edges whose pre-edge phase matches the selected burst-clock edge. For each beat the block places the array address on `beat_addr` and pulses `beat_strobe` for one system clock. The array model outside the block returns the data.

Top module: `burst_seq`

## Requirements
- R1: After reset the configuration is the value 16'h8000 (asynchronous mode, all other fields zero), and `ready`, `beat_strobe` and `cfg_err` are low.
- R2: Bit 15 of the configuration word selects the mode: 1 is asynchronous and 0 is synchronous burst. In asynchronous mode a request produces no beats and leaves `cfg_err` unchanged.
- R3: Bits 13:11 hold the latency code. Codes 001 to 101 give X = 4 to 8 burst-clock edges, counted as X = code + 3. The first beat is taken on the X-th qualifying edge after the edge that accepts the request. `beat_strobe` is high in the system cycle that follows that edge.
- R4: Bit 9 sets the spacing between beats: 0 gives one burst clock (2 system clocks) and 1 gives two burst clocks (4 system clocks).
- R5: Bit 6 selects the burst-clock edge. A system edge qualifies when its pre-edge phase equals this bit. The phase is 0 at the first system edge after reset release and alternates from there.
- R6: Bit 8 sets the ready timing. With 0, `ready` is high exactly in the cycles in which `beat_strobe` is high. With 1, `ready` is high in the system cycle just before every beat and is low once the burst has ended.
- R7: Bits 2:0 set the burst length: 001 gives 4 beats, 010 gives 8 beats, and 111 gives a continuous burst that runs until the request is dropped.
- R8: Let L be the block size (4 or 8) and o the low log2(L) bits of the start address. With bit 7 = 0 (interleaved), beat n reads the address with o replaced by o XOR n, whatever the value of bit 3. With bit 7 = 1 and bit 3 = 0 (wrap), beat n replaces o by (o + n) mod L. With bit 7 = 1 and bit 3 = 1, or with a continuous burst, beat n reads start + n modulo 2^AW.
- R9: A request in synchronous mode with a latency code outside 001..101 or a length code other than 001, 010 or 111 starts no burst and sets `cfg_err` in the next cycle. An accepted request clears `cfg_err`.
- R10: Once the request is sampled low during a burst, no further beat is produced and the burst ends at that edge.
- R11: A burst starts only on a rising request while the block is idle. Holding the request high does not restart it. Configuration writes made during a burst, or on the edge that sees a request rise, are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_wdata | input | 16 | Configuration word |
| burst_req | input | 1 | Address-latch request; its rise starts a burst and holding it high keeps the burst going |
| start_addr | input | AW | First address of the burst, sampled on the accepting edge |
| ready | output | 1 | Data-valid indication, timed by bit 8 |
| beat_addr | output | AW | Array address of the current beat |
| beat_strobe | output | 1 | One-cycle pulse per beat |
| cfg_err | output | 1 | The last synchronous request was refused because of a reserved code |

## Verification
`cfg_err` is due in the first cycle after the edge that sees the request rise. The first beat appears in the cycle after the X-th qualifying edge, and each later beat follows 2 or 4 system clocks after the previous one. The bench keeps its own count of edges since reset and derives the phase from it. From that count it computes the exact edge for each beat, observes at the falling edge that follows, and compares the edge on which the beat occurred and its address. In lead mode it keeps the ready value from the previous cycle, and after the request is dropped it watches six more cycles for stray beats.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  typedef struct packed {
    logic       async_rd;
    logic [2:0] lat_code;
    logic       two_wait;
    logic       rdy_lead;
    logic       linear;
    logic       rise_edge;
    logic       no_wrap;
    logic [2:0] len_code;
  } bcfg_t;

  localparam logic [2:0] LEN_4    = 3'b001;
  localparam logic [2:0] LEN_8    = 3'b010;
  localparam logic [2:0] LEN_CONT = 3'b111;

  // reset image: asynchronous mode, every other field zero
  localparam bcfg_t CFG_RST = bcfg_t'(12'h800);

  function automatic logic lat_legal(input logic [2:0] code);
    return (code != 3'd0) && (code <= 3'd5);
  endfunction

  function automatic logic [3:0] lat_ticks(input logic [2:0] code);
    return {1'b0, code} + 4'd3;
  endfunction

  function automatic logic len_legal(input logic [2:0] code);
    return (code == LEN_4) || (code == LEN_8) || (code == LEN_CONT);
  endfunction

endpackage

// File: rtl/bseq_cfg.sv
module bseq_cfg
  import burst_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [15:0] wr_word,
  output bcfg_t       cfg,
  output logic        cfg_legal
);

  bcfg_t      nxt;
  logic [3:0] unused_bits;

  always_comb begin
    nxt.async_rd  = wr_word[15];
    nxt.lat_code  = wr_word[13:11];
    nxt.two_wait  = wr_word[9];
    nxt.rdy_lead  = wr_word[8];
    nxt.linear    = wr_word[7];
    nxt.rise_edge = wr_word[6];
    nxt.no_wrap   = wr_word[3];
    nxt.len_code  = wr_word[2:0];
  end

  assign unused_bits = {wr_word[14], wr_word[10], wr_word[5:4]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cfg <= CFG_RST;
    else if (wr_en) cfg <= nxt;
  end

  assign cfg_legal = lat_legal(cfg.lat_code) && len_legal(cfg.len_code);

endmodule

// File: rtl/bseq_phase.sv
module bseq_phase (
  input  logic clk,
  input  logic rst_n,
  input  logic rise_sel,
  output logic edge_en
);

  logic ph;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph <= 1'b0;
    else        ph <= ~ph;
  end

  // phase 1 stands for a rising burst-clock edge, phase 0 for a falling one
  assign edge_en = (ph == rise_sel);

endmodule

// File: rtl/bseq_addr.sv
module bseq_addr
  import burst_seq_pkg::*;
#(
  parameter int AW = 20
) (
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] beat_idx,
  input  logic          linear,
  input  logic          no_wrap,
  input  logic [2:0]    len_code,
  output logic [AW-1:0] addr
);

  function automatic logic [AW-1:0] beat_address(
    input logic [AW-1:0] b,
    input logic [AW-1:0] n,
    input logic          lin,
    input logic          nw,
    input logic [2:0]    lc
  );
    logic [2:0] lo, mix, mask;
    lo   = b[2:0];
    mix  = lin ? (lo + n[2:0]) : (lo ^ n[2:0]);
    mask = (lc == LEN_8) ? 3'b111 : 3'b011;
    if ((lc == LEN_CONT) || (lin && nw))
      return b + n;
    return {b[AW-1:3], (lo & ~mask) | (mix & mask)};
  endfunction

  assign addr = beat_address(base, beat_idx, linear, no_wrap, len_code);

endmodule

// File: rtl/burst_seq.sv
module burst_seq
  import burst_seq_pkg::*;
#(
  parameter int AW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [15:0]   cfg_wdata,
  input  logic          burst_req,
  input  logic [AW-1:0] start_addr,
  output logic          ready,
  output logic [AW-1:0] beat_addr,
  output logic          beat_strobe,
  output logic          cfg_err
);

  localparam int WCW = 4;

  bcfg_t          cfg;
  logic           cfg_legal;
  logic           busy, req_q, stb_q, err_q;
  logic [WCW-1:0] wcnt;
  logic [AW-1:0]  beat_idx, base, addr_q, cur_addr;
  logic           s_two, s_lead, s_lin, s_rise, s_nowrap;
  logic [2:0]     s_len;

  // named events, shared with the checker
  logic start_try, start_ok, edge_en, fire, last_beat;
  logic s_big, s_cont, confined, async_mode;

  assign async_mode = cfg.async_rd;
  assign start_try  = burst_req && !req_q && !busy && !cfg.async_rd;
  assign start_ok   = start_try && cfg_legal;
  assign s_big      = (s_len == LEN_8);
  assign s_cont     = (s_len == LEN_CONT);
  assign confined   = !s_cont && (!s_lin || !s_nowrap);
  assign fire       = busy && burst_req && edge_en && (wcnt == WCW'(1));
  assign last_beat  = !s_cont && (beat_idx == AW'(s_big ? 3'd7 : 3'd3));

  bseq_cfg u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (cfg_we && !busy && !start_try),
    .wr_word   (cfg_wdata),
    .cfg       (cfg),
    .cfg_legal (cfg_legal)
  );

  bseq_phase u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .rise_sel (s_rise),
    .edge_en  (edge_en)
  );

  bseq_addr #(.AW(AW)) u_addr (
    .base     (base),
    .beat_idx (beat_idx),
    .linear   (s_lin),
    .no_wrap  (s_nowrap),
    .len_code (s_len),
    .addr     (cur_addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      req_q    <= 1'b0;
      stb_q    <= 1'b0;
      err_q    <= 1'b0;
      wcnt     <= '0;
      beat_idx <= '0;
      base     <= '0;
      addr_q   <= '0;
      s_two    <= 1'b0;
      s_lead   <= 1'b0;
      s_lin    <= 1'b0;
      s_rise   <= 1'b0;
      s_nowrap <= 1'b0;
      s_len    <= '0;
    end else begin
      req_q <= burst_req;
      stb_q <= fire;
      if (fire)      addr_q <= cur_addr;
      if (start_try) err_q  <= ~cfg_legal;
      if (start_ok) begin
        busy     <= 1'b1;
        wcnt     <= lat_ticks(cfg.lat_code);
        beat_idx <= '0;
        base     <= start_addr;
        s_two    <= cfg.two_wait;
        s_lead   <= cfg.rdy_lead;
        s_lin    <= cfg.linear;
        s_rise   <= cfg.rise_edge;
        s_nowrap <= cfg.no_wrap;
        s_len    <= cfg.len_code;
      end else if (busy) begin
        if (!burst_req) begin
          busy <= 1'b0;
        end else if (edge_en) begin
          if (wcnt == WCW'(1)) begin
            beat_idx <= beat_idx + 1'b1;
            wcnt     <= s_two ? WCW'(2) : WCW'(1);
            if (last_beat) busy <= 1'b0;
          end else begin
            wcnt <= wcnt - WCW'(1);
          end
        end
      end
    end
  end

  assign beat_strobe = stb_q;
  assign beat_addr   = addr_q;
  assign cfg_err     = err_q;
  assign ready       = s_lead ? (busy && (wcnt == WCW'(1))) : stb_q;

endmodule

// File: rtl/bseq_chk.sv
module bseq_chk #(
  parameter int AW = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic          burst_req,
  input logic          busy,
  input logic          beat_strobe,
  input logic          ready,
  input logic          lead,
  input logic          start_try,
  input logic          start_ok,
  input logic          cfg_err,
  input logic          async_mode,
  input logic          confined,
  input logic          big,
  input logic [AW-1:0] beat_addr,
  input logic [AW-1:0] base
);

  a_r10_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !burst_req) |=> !busy);

  a_r9_refuse: assert property (@(posedge clk) disable iff (!rst_n)
    (start_try && !start_ok) |=> (cfg_err && !busy));

  a_r4_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    beat_strobe |=> !beat_strobe);

  a_r6_lead: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_strobe && lead) |-> $past(ready));

  a_r2_async_idle: assert property (@(posedge clk) disable iff (!rst_n)
    async_mode |-> !busy);

  a_r8_confine: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_strobe && confined) |-> (((beat_addr ^ base) >> (big ? 3 : 2)) == '0));

endmodule

bind burst_seq bseq_chk #(.AW(AW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .burst_req   (burst_req),
  .busy        (busy),
  .beat_strobe (beat_strobe),
  .ready       (ready),
  .lead        (s_lead),
  .start_try   (start_try),
  .start_ok    (start_ok),
  .cfg_err     (cfg_err),
  .async_mode  (async_mode),
  .confined    (confined),
  .big         (s_big),
  .beat_addr   (beat_addr),
  .base        (base)
);

// File: tb/burst_seq_test.sv
module burst_seq_test;
  localparam int AW = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [15:0]   cfg_wdata = '0;
  logic          burst_req = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic          ready, beat_strobe, cfg_err;
  logic [AW-1:0] beat_addr;

  int   checks = 0, errors = 0, cyc = 0;
  bit   done = 1'b0;
  bit   exp_err = 1'b0;
  logic [15:0] cur_cfg = 16'h8000;

  burst_seq #(.AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .burst_req(burst_req), .start_addr(start_addr), .ready(ready),
    .beat_addr(beat_addr), .beat_strobe(beat_strobe), .cfg_err(cfg_err)
  );

  always #10 clk = ~clk;

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  task automatic check(input bit ok, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  function automatic logic [15:0] mk(input bit asy, input int lat, input bit tw, input bit lead,
                                     input bit lin, input bit rise, input bit nw, input int len);
    logic [15:0] w = '0;
    w[15] = asy; w[13:11] = 3'(lat); w[9] = tw; w[8] = lead;
    w[7] = lin; w[6] = rise; w[3] = nw; w[2:0] = 3'(len);
    return w;
  endfunction

  function automatic logic [AW-1:0] exp_addr(input logic [AW-1:0] b, input int n,
                                             input bit lin, input bit nw, input logic [2:0] lc);
    int unsigned blk_sz = (lc == 3'd2) ? 8 : 4;
    int unsigned off = int'(b) % blk_sz;
    logic [AW-1:0] blk = b - AW'(off);
    if (lc == 3'd7 || (lin && nw)) return b + AW'(n);
    if (lin) return blk + AW'((off + n) % blk_sz);
    return blk + AW'(off ^ n);
  endfunction

  task automatic write_cfg(input logic [15:0] w);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = w;
    @(negedge clk);
    cfg_we = 1'b0;
    cur_cfg = w;
  endtask

  task automatic run_burst(input logic [AW-1:0] sa, input int hold, input int wr_at,
                           input logic [15:0] wr_val, input string tag);
    bit  sync  = !cur_cfg[15];
    int  x     = int'(cur_cfg[13:11]) + 3;
    int  y     = cur_cfg[9] ? 2 : 1;
    bit  lead  = cur_cfg[8];
    bit  lin   = cur_cfg[7];
    int  sel   = int'(cur_cfg[6]);
    bit  nw    = cur_cfg[3];
    logic [2:0] lc = cur_cfg[2:0];
    bit  legal = (cur_cfg[13:11] >= 3'd1) && (cur_cfg[13:11] <= 3'd5) &&
                 (lc == 3'd1 || lc == 3'd2 || lc == 3'd7);
    bit  go    = sync && legal;
    int  lmax  = (lc == 3'd7) ? 32'h3fffffff : ((lc == 3'd2) ? 8 : 4);
    int  c0, t1, cd, nb = 0, nexp = 0;
    bit  prev_rdy = 1'b0;
    c0 = cyc;
    burst_req = 1'b1; start_addr = sa;
    t1 = (((c0 + 1) % 2) == sel) ? c0 + 1 : c0 + 2;
    for (int i = 0; i < hold; i++) begin
      int e;
      @(negedge clk);
      e = cyc - 1;
      if (i == 0) begin
        if (sync) exp_err = !legal;
        check(cfg_err == exp_err, {"R9 R2 error flag ", tag}, cfg_err, exp_err);
      end
      if (beat_strobe) begin
        if (!go || nb >= lmax) begin
          check(1'b0, {"R7 R11 unexpected beat ", tag}, nb, 0);
        end else begin
          int ee = t1 + 2 * (x - 1) + 2 * y * nb;
          check(e == ee, {"R3 R4 R5 beat edge ", tag}, e, ee);
          check(beat_addr == exp_addr(sa, nb, lin, nw, lc), {"R8 beat address ", tag},
                beat_addr, exp_addr(sa, nb, lin, nw, lc));
          if (lead) check(prev_rdy, {"R6 ready lead ", tag}, prev_rdy, 1);
          nb++;
        end
      end
      if (!lead) check(ready == beat_strobe, {"R6 ready with beat ", tag}, ready, beat_strobe);
      prev_rdy = ready;
      if (i == wr_at) begin cfg_we = 1'b1; cfg_wdata = wr_val; end
      else cfg_we = 1'b0;
    end
    cd = cyc;
    burst_req = 1'b0; cfg_we = 1'b0;
    for (int j = 0; j < 6; j++) begin
      @(negedge clk);
      check(!beat_strobe, {"R10 no beat after drop ", tag}, beat_strobe, 0);
      check(!ready, {"R6 R10 ready idle ", tag}, ready, 0);
    end
    if (go) while (nexp < lmax && (t1 + 2 * (x - 1) + 2 * y * nexp) < cd) nexp++;
    check(nb == nexp, {"R7 R10 beat count ", tag}, nb, nexp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!ready && !beat_strobe && !cfg_err, "R1 reset outputs", {ready, beat_strobe, cfg_err}, 0);
    run_burst(20'h00010, 40, -1, 16'h0, "R1 async after reset");
    write_cfg(mk(1, 1, 0, 0, 0, 0, 0, 1));
    run_burst(20'h00020, 40, -1, 16'h0, "R2 async legal fields");
    write_cfg(mk(0, 1, 0, 0, 0, 0, 0, 1));
    run_burst(20'h00013, 80, -1, 16'h0, "R3 lat4 interleave4");
    write_cfg(mk(0, 5, 1, 1, 1, 1, 0, 2));
    run_burst(20'h0000D, 80, -1, 16'h0, "R4 R5 lat8 seqwrap8 lead");
    write_cfg(mk(0, 3, 0, 0, 1, 0, 1, 2));
    run_burst(20'h0000E, 80, -1, 16'h0, "R8 seq nowrap8");
    write_cfg(mk(0, 2, 0, 0, 0, 1, 1, 2));
    run_burst(20'h00035, 80, -1, 16'h0, "R8 interleave nowrap bit");
    write_cfg(mk(0, 2, 0, 1, 0, 1, 0, 7));
    run_burst(20'hFFFFE, 50, -1, 16'h0, "R7 continuous rollover");
    write_cfg(mk(0, 0, 0, 0, 0, 0, 0, 1));
    run_burst(20'h00001, 30, -1, 16'h0, "R9 reserved latency");
    write_cfg(mk(0, 1, 0, 0, 0, 0, 0, 3));
    run_burst(20'h00001, 30, -1, 16'h0, "R9 reserved length");
    write_cfg(mk(0, 4, 1, 0, 1, 0, 0, 1));
    run_burst(20'h00006, 80, -1, 16'h0, "R9 legal clears error");
    write_cfg(mk(0, 1, 0, 0, 1, 0, 0, 2));
    run_burst(20'h00100, 17, -1, 16'h0, "R10 abort mid burst");
    write_cfg(mk(0, 1, 0, 0, 1, 0, 0, 1));
    run_burst(20'h00200, 80, 3, mk(0, 1, 0, 0, 1, 0, 0, 2), "R11 write during burst");
    run_burst(20'h00300, 80, -1, 16'h0, "R11 config kept");
    for (int r = 0; r < 40; r++) begin
      int lat  = int'($urandom_range(5, 1));
      int lsel = int'($urandom_range(2, 0));
      int len  = (lsel == 0) ? 1 : ((lsel == 1) ? 2 : 7);
      int hold = 80;
      if ($urandom_range(9, 0) == 0) lat = 6 + int'($urandom_range(1, 0));
      if ($urandom_range(9, 0) == 0) len = 4;
      write_cfg(mk(0, lat, 1'($urandom), 1'($urandom), 1'($urandom),
                   1'($urandom), 1'($urandom), len));
      if (len == 7 || $urandom_range(4, 0) == 0) hold = int'($urandom_range(60, 10));
      run_burst(AW'($urandom), hold, -1, 16'h0, "random");
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule